// File: doc/BRIEF.md
# Hub Status-Change Interrupt Endpoint

This block keeps the change bitmap of a four-port hub and answers polls on the hub's interrupt-IN endpoint. Change events from the hub itself and from each downstream port set sticky flags. Once per frame, on the end-of-frame marker, the flags are copied into a snapshot. The next IN token is answered from that snapshot.

When an IN token arrives, the block gives one of two answers. It returns a negative handshake if the hub is not yet configured or the snapshot is empty. Otherwise it returns the full status byte as data. A change bit goes on being reported until the host clears it. A simple data toggle tracks the host's acknowledgements of data responses.

Top module: `hub_intr_ep`

## Requirements
- R1: The status byte carries the hub change in bit 0 and downstream ports 1 to 4 in bits 1 to 4. Bits 7 to 5 are always 0.
- R2: Change flags are sticky. An event ORs into its flag and stays there until a clear arrives. If an event and a clear for the same bit arrive in the same cycle, the event wins.
- R3: On a cycle with `eof_mark` high, the snapshot takes the flag values held before that clock edge, with any clear of that cycle applied. Events of the same cycle reach only the next frame's snapshot.
- R4: An IN token gets its response one cycle later on `rsp_kind`. The codes are 0 for none, 1 for NAK and 2 for data. NAK is returned when snapshot bits 4 to 0 are all zero.
- R5: A data response (code 2) carries the snapshot byte on `rsp_data`. `rsp_data` is 0 in every cycle that is not a data response.
- R6: A reported bit stays in every data response until a clear for it arrives. A clear removes the bit from both the flags and the snapshot, effective the next cycle.
- R7: While `configured` is low, every IN token is answered with NAK.
- R8: `rsp_toggle` starts at 0. It flips when `host_ack` follows a data response with no other token in between. It returns to 0 in the cycle after `configured` rises.
- R9: An IN token in the same cycle as `eof_mark` is answered from the previous snapshot.
- R10: After reset, the flags, the snapshot, the toggle and both response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_hub | input | 1 | Hub-level change event |
| evt_port | input | 4 | Per-port change events, bit 0 is port 1 |
| clr_hub | input | 1 | Host clear of the hub change |
| clr_port | input | 4 | Host clear per port, bit 0 is port 1 |
| eof_mark | input | 1 | End-of-frame marker pulse |
| configured | input | 1 | Hub configured by the host |
| in_tok | input | 1 | IN token for the interrupt endpoint |
| host_ack | input | 1 | Host acknowledged the last data response |
| rsp_kind | output | 2 | 0 none, 1 NAK, 2 data |
| rsp_data | output | 8 | Status byte of a data response |
| rsp_toggle | output | 1 | Data toggle |

## Verification
Every result is due exactly one clock after the inputs that cause it. Flags and snapshot update at the edge where an event, clear or marker is sampled. Response code, byte and toggle appear at the edge after the token or acknowledgement. The bench drives inputs on the falling edge. A behavioural model advances on the rising edge, and outputs are compared with it at the following falling edge, before new inputs are applied. Because of this, a token on a marker cycle is checked against the snapshot as it stood before that edge.

// File: rtl/hub_intr_pkg.sv
package hub_intr_pkg;
  localparam int unsigned MAP_W  = 8;
  localparam int unsigned PORTS  = 4;
  localparam int unsigned CHG_W  = PORTS + 1;
  localparam logic [1:0] RSP_IDLE = 2'd0;
  localparam logic [1:0] RSP_NAK  = 2'd1;
  localparam logic [1:0] RSP_DATA = 2'd2;
endpackage

// File: rtl/hub_chg_collect.sv
module hub_chg_collect #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr,
  input  logic         eof_mark,
  output logic [W-1:0] snap
);
  logic [W-1:0] sticky;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        sticky[i] <= 1'b0;
        snap[i]   <= 1'b0;
      end else begin
        sticky[i] <= (sticky[i] & ~clr[i]) | evt[i];
        if (eof_mark) snap[i] <= sticky[i] & ~clr[i];
        else          snap[i] <= snap[i] & ~clr[i];
      end
    end
  end

  // R2
  evt_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((sticky & $past(evt)) == $past(evt)));
  // R3
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!eof_mark && clr == '0) |=> $stable(snap));
  // R6
  clr_snap_chk: assert property (@(posedge clk) disable iff (rst)
    (clr != '0) |=> ((snap & $past(clr)) == '0));
endmodule

// File: rtl/hub_in_responder.sv
module hub_in_responder
  import hub_intr_pkg::*;
#(
  parameter int unsigned W   = CHG_W,
  parameter int unsigned OUT_W = MAP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     snap,
  input  logic             in_tok,
  input  logic             configured,
  input  logic             host_ack,
  output logic [1:0]       rsp_kind,
  output logic [OUT_W-1:0] rsp_data,
  output logic             rsp_toggle
);
  localparam int unsigned PAD = OUT_W - W;

  logic cfg_q;
  logic pend;
  logic give_data;

  assign give_data = configured && (snap != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_kind <= RSP_IDLE;
      rsp_data <= '0;
    end else if (in_tok) begin
      rsp_kind <= give_data ? RSP_DATA : RSP_NAK;
      rsp_data <= give_data ? {{PAD{1'b0}}, snap} : '0;
    end else begin
      rsp_kind <= RSP_IDLE;
      rsp_data <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= 1'b0;
      pend       <= 1'b0;
      rsp_toggle <= 1'b0;
    end else begin
      cfg_q <= configured;
      if (configured && !cfg_q) begin
        rsp_toggle <= 1'b0;
        pend       <= 1'b0;
      end else begin
        if (host_ack && pend) rsp_toggle <= ~rsp_toggle;
        if (in_tok)           pend <= give_data;
        else if (host_ack)    pend <= 1'b0;
      end
    end
  end

  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_data[OUT_W-1:W] == '0);
  // R7
  unconf_nak_chk: assert property (@(posedge clk) disable iff (rst)
    (in_tok && !configured) |=> rsp_kind == RSP_NAK);
  // R5
  data_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_kind == RSP_DATA) |-> (rsp_data != '0));
  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_kind != RSP_DATA) |-> (rsp_data == '0));
  // R8
  tog_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!host_ack && !(configured && !cfg_q)) |=> $stable(rsp_toggle));
endmodule

// File: rtl/hub_intr_ep.sv
module hub_intr_ep
  import hub_intr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_hub,
  input  logic [PORTS-1:0] evt_port,
  input  logic             clr_hub,
  input  logic [PORTS-1:0] clr_port,
  input  logic             eof_mark,
  input  logic             configured,
  input  logic             in_tok,
  input  logic             host_ack,
  output logic [1:0]       rsp_kind,
  output logic [MAP_W-1:0] rsp_data,
  output logic             rsp_toggle
);
  logic [CHG_W-1:0] snap;

  hub_chg_collect #(.W(CHG_W)) u_collect (
    .clk      (clk),
    .rst      (rst),
    .evt      ({evt_port, evt_hub}),
    .clr      ({clr_port, clr_hub}),
    .eof_mark (eof_mark),
    .snap     (snap)
  );

  hub_in_responder #(.W(CHG_W), .OUT_W(MAP_W)) u_resp (
    .clk        (clk),
    .rst        (rst),
    .snap       (snap),
    .in_tok     (in_tok),
    .configured (configured),
    .host_ack   (host_ack),
    .rsp_kind   (rsp_kind),
    .rsp_data   (rsp_data),
    .rsp_toggle (rsp_toggle)
  );
endmodule

// File: tb/hub_intr_ep_tb.sv
module hub_intr_ep_tb;
  logic clk = 0;
  logic rst = 1;
  logic evt_hub = 0, clr_hub = 0, eof_mark = 0, configured = 0, in_tok = 0, host_ack = 0;
  logic [3:0] evt_port = 0, clr_port = 0;
  logic [1:0] rsp_kind;
  logic [7:0] rsp_data;
  logic rsp_toggle;

  int vectors = 0;
  int errors = 0;

  // behavioural model state
  int m_flag [5];
  int m_snap [5];
  int m_kind = 0, m_data = 0, m_tog = 0, m_pend = 0, m_cfg = 0;

  always #5 clk = ~clk;

  hub_intr_ep u_dut (.*);

  function automatic int snap_byte();
    int b = 0;
    for (int i = 0; i < 5; i++) b |= (m_snap[i] << i);
    return b;
  endfunction

  always @(posedge clk) begin
    int ev [5];
    int cl [5];
    int old_snap;
    ev[0] = evt_hub; cl[0] = clr_hub;
    for (int i = 0; i < 4; i++) begin ev[i+1] = evt_port[i]; cl[i+1] = clr_port[i]; end
    if (rst) begin
      for (int i = 0; i < 5; i++) begin m_flag[i] = 0; m_snap[i] = 0; end
      m_kind = 0; m_data = 0; m_tog = 0; m_pend = 0; m_cfg = 0;
    end else begin
      old_snap = snap_byte();
      if (in_tok) begin
        if (configured && old_snap != 0) begin m_kind = 2; m_data = old_snap; end
        else begin m_kind = 1; m_data = 0; end
      end else begin m_kind = 0; m_data = 0; end
      if (configured && !m_cfg) begin m_tog = 0; m_pend = 0; end
      else begin
        if (host_ack && m_pend) m_tog = 1 - m_tog;
        if (in_tok) m_pend = (m_kind == 2);
        else if (host_ack) m_pend = 0;
      end
      m_cfg = configured;
      for (int i = 0; i < 5; i++) begin
        if (eof_mark) m_snap[i] = m_flag[i] & ~cl[i] & 1;
        else          m_snap[i] = m_snap[i] & ~cl[i] & 1;
        m_flag[i] = ((m_flag[i] & ~cl[i]) | ev[i]) & 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle: R4 code, R5 byte, R8 toggle
  task automatic compare();
    chk("R4", rsp_kind, m_kind);
    chk("R5", rsp_data, m_data);
    chk("R8", rsp_toggle, m_tog);
  endtask

  task automatic step(input logic [4:0] ev, input logic [4:0] cl, input logic eof,
                      input logic cfg, input logic tok, input logic ack);
    @(negedge clk);
    compare();
    evt_hub = ev[0]; evt_port = ev[4:1];
    clr_hub = cl[0]; clr_port = cl[4:1];
    eof_mark = eof; configured = cfg; in_tok = tok; host_ack = ack;
  endtask

  task automatic idle(input logic cfg);
    step(5'b0, 5'b0, 1'b0, cfg, 1'b0, 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst = 0;
    // R10: reset state
    @(negedge clk);
    chk("R10", rsp_kind, 0);
    chk("R10", rsp_data, 0);
    chk("R10", rsp_toggle, 0);
    // R7: unconfigured hub NAKs even with a pending change
    step(5'b00100, 5'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(5'b0, 5'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    step(5'b0, 5'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    idle(1'b0);
    chk("R7", rsp_kind, 1);
    // configure: toggle cleared (R8); port2 bit2 reported (R1, R5)
    idle(1'b1);
    step(5'b0, 5'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    idle(1'b1);
    chk("R5", rsp_data, 8'h04);
    // ack flips toggle (R8)
    step(5'b0, 5'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    idle(1'b1);
    chk("R8", rsp_toggle, 1);
    // R6: repeated report until clear
    step(5'b0, 5'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    idle(1'b1);
    chk("R6", rsp_data, 8'h04);
    step(5'b0, 5'b00100, 1'b0, 1'b1, 1'b0, 1'b0);
    step(5'b0, 5'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    idle(1'b1);
    chk("R6", rsp_kind, 1);
    // R9 / R3: event then token on the marker cycle answers old (empty) snapshot
    step(5'b10001, 5'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    step(5'b0, 5'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    idle(1'b1);
    chk("R9", rsp_kind, 1);
    step(5'b0, 5'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    idle(1'b1);
    chk("R3", rsp_data, 8'h11);
    // R2: event and clear together keep the flag
    step(5'b00010, 5'b00010, 1'b0, 1'b1, 1'b0, 1'b0);
    step(5'b0, 5'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    step(5'b0, 5'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    idle(1'b1);
    chk("R2", rsp_data & 8'h02, 8'h02);
    // random traffic, compared every cycle against the model (R1 reserved bits)
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] ev, cl;
      ev = (($urandom % 4) == 0) ? 5'($urandom) : 5'b0;
      cl = (($urandom % 3) == 0) ? 5'($urandom) : 5'b0;
      step(ev, cl, ($urandom % 8) == 0, ($urandom % 200) != 0,
           ($urandom % 3) == 0, ($urandom % 3) == 0);
      chk("R1", rsp_data & 8'hE0, 0);
    end
    idle(1'b1);
    idle(1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule